// File: doc/BRIEF.md
# Seven-to-one pixel link serializer

This block turns one 28-bit pixel word per pixel-clock period into four serial data lanes. Each lane carries seven bits per period. A fifth lane carries a forwarded clock at the pixel rate. A bit clock running at seven times the pixel rate is an input; it stands in for the multiplying PLL. The pixel clock is sampled as a signal in the bit-clock domain. A select pin picks whether its rising or its falling transition captures the word.

The captured word waits in a holding register. Lane shift registers load from it on a load pulse, which a mod-7 phase counter issues. The counter re-aligns to every capture edge, so each serial frame starts a fixed number of bit clocks after that edge. Outputs are modelled as single-ended bits with a common output enable. A low enable stands for high impedance, and the data bits are then driven low.

An active-low power-down pin disables every lane on the next bit clock. After the pin is released, the outputs stay disabled for a programmable lock-settling interval, counted in bit clocks. They come back on at the start of a frame. Releasing the pin again always restarts that interval from zero.

Top module: `pixlink_ser7_tx`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `lane_oe`, `lane_clk` and all of `lane_dat` are 0.
- R2: With `edge_sel`=1, a low-to-high step of `pix_clk` captures `pix_word`. With `edge_sel`=0, a high-to-low step does, and this is the setting to tie off for falling-edge capture. The step is seen at bit-clock edge E, where `pix_clk` differs from its value at E-1. Slots 0..6 of that word then appear after edges E+1 through E+7.
- R3: The word fields are: bits 7:0 red, 15:8 green, 23:16 blue, 24 horizontal sync, 25 vertical sync, 26 data enable, 27 spare. The word bits sent in slots 0..6 of each lane are:
  - lane 0: bits 0,1,2,3,4,5,8
  - lane 1: bits 9,10,11,12,13,16,17
  - lane 2: bits 18,19,20,21,24,25,26
  - lane 3: bits 6,7,14,15,22,23,27
- R4: Each lane sends one slot per bit clock, slot 0 first and slot 6 last, with no gap between frames.
- R5: While enabled, `lane_clk` repeats the slot pattern 1,1,0,0,0,1,1 in step with the data slots, so every seven consecutive enabled bit clocks hold exactly four ones.
- R6: A low `pd_n` seen at a bit-clock edge makes `lane_oe`, `lane_clk` and `lane_dat` all 0 after the next edge, and they stay so while `pd_n` stays low.
- R7: Call P the first edge that sees `pd_n` high after reset or power-down. `lane_oe` first rises after edge P+m, where LOCK_CYCLES+1 <= m <= LOCK_CYCLES+7. It rises on slot 0, so `lane_clk` is 1 in that cycle.
- R8: A power-down during the lock wait discards the elapsed count, and the next release waits the full interval again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, seven times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| pix_clk | input | 1 | Pixel clock, sampled in the bit-clock domain |
| edge_sel | input | 1 | 1: rising-step capture, 0: falling-step capture |
| pd_n | input | 1 | Active-low power-down |
| pix_word | input | 28 | Parallel pixel word (colour and control fields) |
| lane_dat | output | 4 | Serial data lanes, slot 0 first |
| lane_clk | output | 1 | Forwarded clock lane |
| lane_oe | output | 1 | Output enable for all five lanes (0 models high impedance) |

## Verification
The bound checker watches the following on every cycle:
- every lane turns off on the cycle after a power-down;
- the enable rises only after the full lock count and only on a frame whose clock slot is high;
- any seven enabled cycles of the clock lane hold four ones.

The lane-to-bit mapping, the slot order, and which pixel-clock step captures the word can only be shown by the bench's scenarios. The bench deserializes all five lanes, aligns on the clock pattern and compares against the words it drove, under both capture settings. Likewise, only the bench can show that the lock count restarts when power-down interrupts it.

// File: rtl/pixlink_pkg.sv
package pixlink_pkg;

    localparam int LANES   = 4;
    localparam int SLOTS   = 7;
    localparam int WORD_W  = 28;
    localparam int PHASE_W = $clog2(SLOTS);

    typedef struct packed {
        logic       spare;
        logic       de;
        logic       vsync;
        logic       hsync;
        logic [7:0] blu;
        logic [7:0] grn;
        logic [7:0] red;
    } pix_word_t;

    // bit i is sent in slot i
    localparam logic [SLOTS-1:0] FWD_CLK_FRAME = 7'b1100011;

    typedef enum logic [1:0] {
        PWR_OFF  = 2'd0,
        PWR_LOCK = 2'd1,
        PWR_RUN  = 2'd2
    } pwr_state_t;

    // Slot i of the returned frame is bit i.
    function automatic logic [SLOTS-1:0] lane_frame(pix_word_t w, int lane);
        logic [SLOTS-1:0] f;
        case (lane)
            0:       f = {w.grn[0], w.red[5:0]};
            1:       f = {w.blu[1:0], w.grn[5:1]};
            2:       f = {w.de, w.vsync, w.hsync, w.blu[5:2]};
            default: f = {w.spare, w.blu[7:6], w.grn[7:6], w.red[7:6]};
        endcase
        return f;
    endfunction

endpackage

// File: rtl/pxl_capture.sv
module pxl_capture
    import pixlink_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_clk,
    input  logic              edge_sel,
    input  logic [WORD_W-1:0] pix_word,
    output logic              strobe,
    output logic [WORD_W-1:0] hold_word
);

    logic pclk_q;

    always_comb begin
        if (edge_sel) strobe = pix_clk & ~pclk_q;
        else          strobe = ~pix_clk & pclk_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pclk_q    <= 1'b0;
            hold_word <= '0;
        end else begin
            pclk_q <= pix_clk;
            if (strobe) hold_word <= pix_word;
        end
    end

endmodule

// File: rtl/pxl_framer.sv
module pxl_framer
    import pixlink_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    output logic load
);

    localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(SLOTS - 1);
    localparam logic [PHASE_W-1:0] LOAD_PHASE = PHASE_W'(1);

    logic [PHASE_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst)                      phase <= '0;
        else if (strobe)              phase <= LOAD_PHASE;
        else if (phase == LAST_PHASE) phase <= '0;
        else                          phase <= phase + 1'b1;
    end

    assign load = (phase == LOAD_PHASE);

endmodule

// File: rtl/pxl_lane_shift.sv
module pxl_lane_shift
    import pixlink_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [SLOTS-1:0] par,
    output logic             ser
);

    logic [SLOTS-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst)       sr <= '0;
        else if (load) sr <= par;
        else           sr <= sr >> 1;
    end

    assign ser = sr[0];

endmodule

// File: rtl/pxl_power_seq.sv
module pxl_power_seq
    import pixlink_pkg::*;
#(
    parameter int LOCK_CYCLES = 5_950_000
) (
    input  logic clk,
    input  logic rst,
    input  logic pd_n,
    input  logic load,
    output logic oe
);

    localparam int              CNT_W = $clog2(LOCK_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LOCK_CYCLES);

    pwr_state_t       state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PWR_OFF;
            cnt   <= '0;
        end else begin
            case (state)
                PWR_OFF: begin
                    cnt <= '0;
                    if (pd_n) state <= PWR_LOCK;
                end
                PWR_LOCK: begin
                    if (!pd_n) begin
                        state <= PWR_OFF;
                    end else if (cnt == LIMIT) begin
                        if (load) state <= PWR_RUN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PWR_RUN: if (!pd_n) state <= PWR_OFF;
                default: state <= PWR_OFF;
            endcase
        end
    end

    assign oe = (state == PWR_RUN);

endmodule

// File: rtl/pixlink_ser7_tx.sv
module pixlink_ser7_tx
    import pixlink_pkg::*;
#(
    parameter int LOCK_CYCLES = 5_950_000
) (
    input  logic              clk_bit,
    input  logic              rst,
    input  logic              pix_clk,
    input  logic              edge_sel,
    input  logic              pd_n,
    input  logic [WORD_W-1:0] pix_word,
    output logic [LANES-1:0]  lane_dat,
    output logic              lane_clk,
    output logic              lane_oe
);

    logic              strobe;
    logic              load;
    logic [WORD_W-1:0] hold_word;
    pix_word_t         held;
    logic [LANES-1:0]  ser_dat;
    logic              ser_clk;

    pxl_capture u_capture (
        .clk       (clk_bit),
        .rst       (rst),
        .pix_clk   (pix_clk),
        .edge_sel  (edge_sel),
        .pix_word  (pix_word),
        .strobe    (strobe),
        .hold_word (hold_word)
    );

    assign held = pix_word_t'(hold_word);

    pxl_framer u_framer (
        .clk    (clk_bit),
        .rst    (rst),
        .strobe (strobe),
        .load   (load)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        pxl_lane_shift u_shift (
            .clk  (clk_bit),
            .rst  (rst),
            .load (load),
            .par  (lane_frame(held, l)),
            .ser  (ser_dat[l])
        );
    end

    pxl_lane_shift u_clk_shift (
        .clk  (clk_bit),
        .rst  (rst),
        .load (load),
        .par  (FWD_CLK_FRAME),
        .ser  (ser_clk)
    );

    pxl_power_seq #(.LOCK_CYCLES(LOCK_CYCLES)) u_power (
        .clk  (clk_bit),
        .rst  (rst),
        .pd_n (pd_n),
        .load (load),
        .oe   (lane_oe)
    );

    assign lane_dat = lane_oe ? ser_dat : '0;
    assign lane_clk = lane_oe & ser_clk;

endmodule

// File: rtl/pixlink_ser7_tx_chk.sv
module pixlink_ser7_tx_chk #(
    parameter int LOCK_CYCLES = 5_950_000
) (
    input logic       clk_bit,
    input logic       rst,
    input logic       pd_n,
    input logic [3:0] lane_dat,
    input logic       lane_clk,
    input logic       lane_oe
);

    logic [31:0] since_on;
    logic [3:0]  oe_run;
    logic [6:0]  clk_hist;

    always_ff @(posedge clk_bit) begin
        if (rst) begin
            since_on <= '0;
            oe_run   <= '0;
            clk_hist <= '0;
        end else begin
            if (!pd_n)                  since_on <= '0;
            else if (since_on != '1)    since_on <= since_on + 1'b1;
            if (!lane_oe)               oe_run <= '0;
            else if (oe_run != 4'd15)   oe_run <= oe_run + 1'b1;
            clk_hist <= {clk_hist[5:0], lane_clk};
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk_bit)
        rst |=> (!lane_oe && !lane_clk && lane_dat == 4'd0));

    a_r6_powerdown_off: assert property (@(posedge clk_bit) disable iff (rst)
        !pd_n |=> (!lane_oe && !lane_clk && lane_dat == 4'd0));

    a_r7_lock_window: assert property (@(posedge clk_bit) disable iff (rst)
        $rose(lane_oe) |-> (since_on > 32'(LOCK_CYCLES)));

    a_r7_frame_start: assert property (@(posedge clk_bit) disable iff (rst)
        $rose(lane_oe) |-> lane_clk);

    a_r5_clock_ones: assert property (@(posedge clk_bit) disable iff (rst)
        (oe_run >= 4'd7) |-> ($countones(clk_hist) == 4));

endmodule

bind pixlink_ser7_tx pixlink_ser7_tx_chk #(.LOCK_CYCLES(LOCK_CYCLES)) u_chk (
    .clk_bit  (clk_bit),
    .rst      (rst),
    .pd_n     (pd_n),
    .lane_dat (lane_dat),
    .lane_clk (lane_clk),
    .lane_oe  (lane_oe)
);

// File: tb/test_pixlink_ser7_tx.sv
module test_pixlink_ser7_tx;

    localparam int LOCK = 40;
    localparam int MAP [4][7] = '{
        '{0, 1, 2, 3, 4, 5, 8},
        '{9, 10, 11, 12, 13, 16, 17},
        '{18, 19, 20, 21, 24, 25, 26},
        '{6, 7, 14, 15, 22, 23, 27}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pix_clk = 1'b0;
    logic        edge_sel = 1'b1;
    logic        pd_n = 1'b1;
    logic [27:0] pix_word = '0;
    logic [3:0]  lane_dat;
    logic        lane_clk;
    logic        lane_oe;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int idx = 0;
    int last_edge = -1;
    int frames = 0;

    always #4 clk = ~clk;

    pixlink_ser7_tx #(.LOCK_CYCLES(LOCK)) i_pixlink_ser7_tx (
        .clk_bit  (clk),
        .rst      (rst),
        .pix_clk  (pix_clk),
        .edge_sel (edge_sel),
        .pd_n     (pd_n),
        .pix_word (pix_word),
        .lane_dat (lane_dat),
        .lane_clk (lane_clk),
        .lane_oe  (lane_oe)
    );

    function automatic logic [27:0] wgen(int k);
        int m = k % 40;
        if (m < 28) return 28'(1) << m;
        return 28'((k * 32'h2545F491) ^ (k << 11));
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // pixel source: word and active step at phase 0, opposite step at phase 3
    initial begin
        int pc = 0;
        forever begin
            @(negedge clk);
            if (pc == 0) begin
                pix_word  = wgen(idx);
                idx       = idx + 1;
                pix_clk   = edge_sel;
                last_edge = cyc + 1;
            end else if (pc == 3) begin
                pix_clk = ~edge_sel;
            end
            pc = (pc + 1) % 7;
        end
    end

    // deserializer: align on clock-lane pattern, rebuild word
    logic [6:0] ch = '0;
    logic [6:0] dh [4];
    int run = 0;
    int prev_frame = -1;
    always @(negedge clk) begin
        if (!lane_oe) begin
            run = 0;
            prev_frame = -1;
        end else begin
            logic [27:0] rec;
            logic [27:0] expw;
            ch = {ch[5:0], lane_clk};
            for (int l = 0; l < 4; l++) dh[l] = {dh[l][5:0], lane_dat[l]};
            run = run + 1;
            if (run >= 7 && ch == 7'b1100011) begin
                rec = '0;
                for (int l = 0; l < 4; l++)
                    for (int s = 0; s < 7; s++) rec[MAP[l][s]] = dh[l][6-s];
                expw = wgen(idx - 2);
                checks++;
                if (rec !== expw) begin
                    errors++;
                    $display("FAIL R3 R4 recovered word %h expected %h", rec, expw);
                end
                checks++;
                if (cyc != last_edge) begin
                    errors++;
                    $display("FAIL R2 frame ends at cycle %0d expected %0d", cyc, last_edge);
                end
                if (prev_frame >= 0) begin
                    checks++;
                    if (cyc - prev_frame != 7) begin
                        errors++;
                        $display("FAIL R5 frame spacing %0d expected 7", cyc - prev_frame);
                    end
                end
                prev_frame = cyc;
                frames = frames + 1;
            end
        end
    end

    task automatic check(input bit ok, input string msg, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", msg, act, expv);
        end
    endtask

    task automatic wait_oe(output int n);
        n = 0;
        while (n < LOCK + 20) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (lane_oe) break;
        end
    endtask

    task automatic run_frames(input int periods, input string tag);
        int f0 = frames;
        repeat (7 * periods) @(negedge clk);
        check(frames - f0 >= periods - 2, tag, frames - f0, periods - 2);
    endtask

    task automatic power_down(input int len);
        int bad = 0;
        @(negedge clk);
        pd_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(!lane_oe && !lane_clk && lane_dat == 4'd0, "R6 outputs off after power-down",
              {lane_oe, lane_clk, lane_dat}, 0);
        repeat (len) begin
            @(negedge clk);
            if (lane_oe || lane_clk || lane_dat != 4'd0) bad++;
        end
        check(bad == 0, "R6 outputs stay off while powered down", bad, 0);
    endtask

    task automatic release_and_check(input string tag);
        int n;
        pd_n = 1'b1;
        wait_oe(n);
        check(n - 1 >= LOCK + 1 && n - 1 <= LOCK + 7, tag, n - 1, LOCK + 1);
        check(lane_clk == 1'b1, "R7 enable rises on slot 0", lane_clk, 1);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check(!lane_oe && !lane_clk && lane_dat == 4'd0, "R1 outputs quiet in reset",
              {lane_oe, lane_clk, lane_dat}, 0);
        rst = 1'b0;
        check(!lane_oe && !lane_clk && lane_dat == 4'd0, "R1 outputs quiet after reset",
              {lane_oe, lane_clk, lane_dat}, 0);
        release_and_check("R7 lock wait after reset");
        run_frames(25, "R3 frames recovered, rising capture (R2)");

        power_down(12);
        edge_sel = 1'b0;
        @(negedge clk);
        release_and_check("R7 lock wait after power-down");
        run_frames(25, "R3 frames recovered, falling capture (R2)");

        power_down(3);
        pd_n = 1'b1;
        repeat (LOCK / 2) @(negedge clk);
        check(!lane_oe, "R8 still waiting mid-lock", lane_oe, 0);
        pd_n = 1'b0;
        repeat (2) @(negedge clk);
        release_and_check("R8 lock wait restarts from zero");
        run_frames(15, "R4 frames continue after restart");

        power_down(5);
        edge_sel = 1'b1;
        @(negedge clk);
        release_and_check("R7 lock wait back to rising capture");
        run_frames(15, "R2 frames recovered after edge change");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual %0d expected 0", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule